// File: doc/BRIEF.md
# Stepped Frequency Ramp Generator

This block drives the fractional part of a synthesizer's feedback divider with a signed offset that moves in discrete steps. It runs on the reference-comparison clock. A dwell divider decides how many comparison cycles each step lasts. A signed deviation word, scaled by a power-of-two exponent, decides how far the offset moves on each step. A step count decides how many steps make up one sweep. The output offset is added elsewhere to the programmed base fraction.

Four sweep shapes are available:
- a one-shot burst that stops at the top;
- a one-shot sawtooth that drops back to zero and stays there;
- a looping sawtooth;
- a triangle.

Two word sets, each holding a step count and a deviation, can be used in two ways. A select bit can pick one of them for the whole sweep. Alternatively, the two sets can be chained so that one sweep has two slopes. An optional delay can hold off the first sweep. In the looping sawtooth, the same delay can also be inserted between sweeps. A frequency-shift term can be overlaid on the output. A capture input latches the present output into a readback word without disturbing the sweep.

Top module: `ramp_sweep_gen`

## Requirements
- R1: While reset is asserted and after its release, with the sweep disabled, `offset_o` and `readback_o` are zero.
- R2: After enable, the internal offset changes only on dwell ticks. Dwell ticks fall every `dwell_div_i` cycles, and the first tick comes `dwell_div_i` cycles after the enabling edge. Each step adds the deviation word sign-extended and shifted left by `dev_shift_i`. `offset_o` shows the internal offset one cycle later.
- R3: `mode_i` = 0 (burst): after N steps the offset holds at the peak.
- R4: `mode_i` = 1 (single sawtooth): on the tick after the N-th step the offset returns to zero and stays there.
- R5: `mode_i` = 2 (looping sawtooth): the sweep of N steps plus a return-to-zero tick repeats without end, a period of N+1 ticks.
- R6: `mode_i` = 3 (triangle): N steps up, then N steps down that retrace the same increments in reverse order, repeating.
- R7: With `dual_i` = 0, `set_sel_i` = 0 uses set A (`steps_a_i`, `dev_a_i`) and `set_sel_i` = 1 uses set B, so N is that set's step count.
- R8: With `dual_i` = 1, a rising sweep takes `steps_a_i` steps of deviation A and then `steps_b_i` steps of deviation B, so N = A+B. A falling sweep takes the B steps first.
- R9: With `start_dly_en_i` = 1, the first sweep starts `dly_len_i` delay units after enable. A delay unit is one comparison cycle when `dly_unit_i` = 0 and one dwell period when `dly_unit_i` = 1.
- R10: With `gap_dly_en_i` = 1 in mode 2, the same delay is inserted after each return to zero before the next sweep starts.
- R11: With `fsk_en_i` = 1 and `fsk_bit_i` = 1, the output carries an extra `fsk_dev_i` shifted by `dev_shift_i`, one cycle after the bit is sampled. `fsk_bit_i` has no effect when `fsk_en_i` = 0.
- R12: Deasserting `ramp_en_i` clears the internal offset and all counters at the next edge, and `offset_o` reads zero one cycle after that.
- R13: A cycle with `irq_i` high copies `offset_o` into `readback_o` at that edge; the sweep itself continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Comparison clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ramp_en_i | input | 1 | Sweep enable |
| mode_i | input | 2 | Sweep shape: 0 burst, 1 single sawtooth, 2 looping sawtooth, 3 triangle |
| dual_i | input | 1 | Chain set A and set B in one sweep |
| set_sel_i | input | 1 | Set choice when not chained (0 = A, 1 = B) |
| steps_a_i | input | STEP_W | Step count of set A |
| steps_b_i | input | STEP_W | Step count of set B |
| dev_a_i | input | DEV_W | Signed deviation of set A |
| dev_b_i | input | DEV_W | Signed deviation of set B |
| dev_shift_i | input | SHIFT_W | Left-shift exponent for all deviations |
| dwell_div_i | input | DIV_W | Comparison cycles per step |
| start_dly_en_i | input | 1 | Delay before the first sweep |
| gap_dly_en_i | input | 1 | Delay between looping sawtooth sweeps |
| dly_unit_i | input | 1 | Delay unit: 0 cycle, 1 dwell period |
| dly_len_i | input | DLY_W | Delay length in units |
| fsk_en_i | input | 1 | Allow the shift overlay |
| fsk_bit_i | input | 1 | Shift data bit |
| fsk_dev_i | input | DEV_W | Signed shift deviation |
| irq_i | input | 1 | Capture the output into the readback word |
| offset_o | output | OUT_W | Signed frequency offset |
| readback_o | output | OUT_W | Captured offset |

## Verification
The assertions take for granted that every configuration word stays constant while `ramp_en_i` is high. They also assume that the dwell divider, the step counts and the delay length are nonzero. The hold, zero-return and no-peak-in-triangle properties read the live `mode_i`, so a mode change mid-sweep would be outside what they cover. The stimulus respects these conditions by rewriting the configuration only after the sweep has been disabled and the disabling edge has passed. It also uses only nonzero counts across the whole sweep of shapes, set choices and delay variants.

// File: rtl/ramp_sweep_pkg.sv
package ramp_sweep_pkg;

  typedef enum logic [1:0] {
    MODE_BURST    = 2'd0,
    MODE_SAW_ONCE = 2'd1,
    MODE_SAW_LOOP = 2'd2,
    MODE_TRIANGLE = 2'd3
  } sweep_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RISE,
    ST_FALL,
    ST_PEAK,
    ST_HOLD
  } seq_state_e;

endpackage

// File: rtl/ramp_dwell_timer.sv
module ramp_dwell_timer #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (DIV_W+1)'(1);
  // a divider of zero behaves as one
  assign tick_o  = run_i && (cnt_inc >= {1'b0, div_i});

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (run_i) cnt_d = tick_o ? '0 : cnt_inc[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_lt_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i != '0) |-> (cnt_q < div_i));

endmodule

// File: rtl/ramp_step_seq.sv
module ramp_step_seq
  import ramp_sweep_pkg::*;
#(
  parameter int STEP_W = 20,
  parameter int DLY_W  = 12,
  parameter int OUT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic [1:0]              mode_i,
  input  logic                    dual_i,
  input  logic                    sel_i,
  input  logic [STEP_W-1:0]       lim_a_i,
  input  logic [STEP_W-1:0]       lim_b_i,
  input  logic signed [OUT_W-1:0] inc_a_i,
  input  logic signed [OUT_W-1:0] inc_b_i,
  input  logic                    start_dly_en_i,
  input  logic                    gap_en_i,
  input  logic                    dly_unit_i,
  input  logic [DLY_W-1:0]        dly_len_i,
  input  logic                    tick_i,
  output logic                    timer_run_o,
  output logic                    timer_clr_o,
  output logic signed [OUT_W-1:0] acc_o
);

  sweep_mode_e mode;
  seq_state_e  st_q, st_d;
  logic                    seg_q, seg_d;
  logic [STEP_W-1:0]       step_q, step_d;
  logic [DLY_W-1:0]        dcnt_q, dcnt_d;
  logic signed [OUT_W-1:0] acc_q, acc_d;

  logic                    use_b;
  logic [STEP_W-1:0]       lim_cur;
  logic signed [OUT_W-1:0] inc_cur;
  logic [STEP_W:0]         step_inc;
  logic [DLY_W:0]          dcnt_inc;
  logic                    seg_last, dly_adv, dly_done;

  assign mode     = sweep_mode_e'(mode_i);
  assign use_b    = dual_i ? seg_q : sel_i;
  assign lim_cur  = use_b ? lim_b_i : lim_a_i;
  assign inc_cur  = use_b ? inc_b_i : inc_a_i;
  assign step_inc = {1'b0, step_q} + (STEP_W+1)'(1);
  assign seg_last = step_inc >= {1'b0, lim_cur};
  assign dcnt_inc = {1'b0, dcnt_q} + (DLY_W+1)'(1);
  assign dly_adv  = (st_q == ST_WAIT) && (dly_unit_i ? tick_i : 1'b1);
  assign dly_done = dly_adv && (dcnt_inc >= {1'b0, dly_len_i});

  assign timer_run_o = (st_q == ST_WAIT) || (st_q == ST_RISE) ||
                       (st_q == ST_FALL) || (st_q == ST_PEAK);
  assign timer_clr_o = !en_i || (st_q == ST_IDLE) || dly_done;
  assign acc_o       = acc_q;

  always_comb begin
    st_d   = st_q;
    seg_d  = seg_q;
    step_d = step_q;
    dcnt_d = dcnt_q;
    acc_d  = acc_q;
    if (!en_i) begin
      st_d   = ST_IDLE;
      seg_d  = 1'b0;
      step_d = '0;
      dcnt_d = '0;
      acc_d  = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          seg_d  = 1'b0;
          step_d = '0;
          dcnt_d = '0;
          acc_d  = '0;
          st_d   = start_dly_en_i ? ST_WAIT : ST_RISE;
        end
        ST_WAIT: begin
          if (dly_done) begin
            dcnt_d = '0;
            st_d   = ST_RISE;
          end else if (dly_adv) begin
            dcnt_d = dcnt_inc[DLY_W-1:0];
          end
        end
        ST_RISE: begin
          if (tick_i) begin
            acc_d = acc_q + inc_cur;
            if (seg_last) begin
              step_d = '0;
              if (dual_i && !seg_q) begin
                seg_d = 1'b1;
              end else begin
                unique case (mode)
                  MODE_BURST:    st_d = ST_HOLD;
                  MODE_TRIANGLE: st_d = ST_FALL;
                  default:       st_d = ST_PEAK;
                endcase
              end
            end else begin
              step_d = step_inc[STEP_W-1:0];
            end
          end
        end
        ST_FALL: begin
          if (tick_i) begin
            acc_d = acc_q - inc_cur;
            if (seg_last) begin
              step_d = '0;
              if (dual_i && seg_q) begin
                seg_d = 1'b0;
              end else begin
                seg_d = 1'b0;
                st_d  = ST_RISE;
              end
            end else begin
              step_d = step_inc[STEP_W-1:0];
            end
          end
        end
        ST_PEAK: begin
          if (tick_i) begin
            acc_d  = '0;
            seg_d  = 1'b0;
            step_d = '0;
            dcnt_d = '0;
            if (mode == MODE_SAW_ONCE) st_d = ST_HOLD;
            else if (gap_en_i)         st_d = ST_WAIT;
            else                       st_d = ST_RISE;
          end
        end
        ST_HOLD: ;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      seg_q  <= 1'b0;
      step_q <= '0;
      dcnt_q <= '0;
      acc_q  <= '0;
    end else begin
      st_q   <= st_d;
      seg_q  <= seg_d;
      step_q <= step_d;
      dcnt_q <= dcnt_d;
      acc_q  <= acc_d;
    end
  end

  // R12
  clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (acc_q == '0));

  // R2
  move_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q != $past(acc_q)) |-> ($past(tick_i) || $past(!en_i)));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && en_i) |=> (acc_q == $past(acc_q)));

  // R4
  once_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && mode == MODE_SAW_ONCE) |-> (acc_q == '0));

  // R6
  tri_no_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEAK) |-> (mode != MODE_TRIANGLE));

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> ((dcnt_q < dly_len_i) || (dcnt_q == '0)));

endmodule

// File: rtl/ramp_out_stage.sv
module ramp_out_stage #(
  parameter int OUT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic signed [OUT_W-1:0] acc_i,
  input  logic                    fsk_en_i,
  input  logic                    fsk_bit_i,
  input  logic signed [OUT_W-1:0] fsk_inc_i,
  input  logic                    irq_i,
  output logic [OUT_W-1:0]        off_o,
  output logic [OUT_W-1:0]        rb_o
);

  logic signed [OUT_W-1:0] off_q, off_d;
  logic [OUT_W-1:0]        rb_q, rb_d;
  logic                    shift_on;

  assign shift_on = en_i && fsk_en_i && fsk_bit_i;

  always_comb begin
    off_d = shift_on ? (acc_i + fsk_inc_i) : acc_i;
    rb_d  = irq_i ? off_q : rb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      rb_q  <= '0;
    end else begin
      off_q <= off_d;
      rb_q  <= rb_d;
    end
  end

  assign off_o = off_q;
  assign rb_o  = rb_q;

  // R11
  plain_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fsk_en_i |=> (off_q == $past(acc_i)));

  // R13
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> (rb_q == $past(off_q)));

  // R13
  rb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_i |=> $stable(rb_q));

endmodule

// File: rtl/ramp_sweep_gen.sv
module ramp_sweep_gen #(
  parameter int STEP_W  = 20,
  parameter int DEV_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int DIV_W   = 12,
  parameter int DLY_W   = 12,
  parameter int OUT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ramp_en_i,
  input  logic [1:0]         mode_i,
  input  logic               dual_i,
  input  logic               set_sel_i,
  input  logic [STEP_W-1:0]  steps_a_i,
  input  logic [STEP_W-1:0]  steps_b_i,
  input  logic [DEV_W-1:0]   dev_a_i,
  input  logic [DEV_W-1:0]   dev_b_i,
  input  logic [SHIFT_W-1:0] dev_shift_i,
  input  logic [DIV_W-1:0]   dwell_div_i,
  input  logic               start_dly_en_i,
  input  logic               gap_dly_en_i,
  input  logic               dly_unit_i,
  input  logic [DLY_W-1:0]   dly_len_i,
  input  logic               fsk_en_i,
  input  logic               fsk_bit_i,
  input  logic [DEV_W-1:0]   fsk_dev_i,
  input  logic               irq_i,
  output logic [OUT_W-1:0]   offset_o,
  output logic [OUT_W-1:0]   readback_o
);

  localparam int EXT_W  = OUT_W - DEV_W;
  localparam int N_WORD = 3;

  logic [DEV_W-1:0]        dev_w [N_WORD];
  logic signed [OUT_W-1:0] inc_w [N_WORD];
  logic                    tick, run, clr;
  logic signed [OUT_W-1:0] acc;

  assign dev_w[0] = dev_a_i;
  assign dev_w[1] = dev_b_i;
  assign dev_w[2] = fsk_dev_i;

  for (genvar g = 0; g < N_WORD; g++) begin : g_scale
    assign inc_w[g] = $signed({{EXT_W{dev_w[g][DEV_W-1]}}, dev_w[g]}) <<< dev_shift_i;
  end

  ramp_dwell_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .clr_i  (clr),
    .div_i  (dwell_div_i),
    .tick_o (tick)
  );

  ramp_step_seq #(
    .STEP_W (STEP_W),
    .DLY_W  (DLY_W),
    .OUT_W  (OUT_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_i           (ramp_en_i),
    .mode_i         (mode_i),
    .dual_i         (dual_i),
    .sel_i          (set_sel_i),
    .lim_a_i        (steps_a_i),
    .lim_b_i        (steps_b_i),
    .inc_a_i        (inc_w[0]),
    .inc_b_i        (inc_w[1]),
    .start_dly_en_i (start_dly_en_i),
    .gap_en_i       (gap_dly_en_i),
    .dly_unit_i     (dly_unit_i),
    .dly_len_i      (dly_len_i),
    .tick_i         (tick),
    .timer_run_o    (run),
    .timer_clr_o    (clr),
    .acc_o          (acc)
  );

  ramp_out_stage #(.OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (ramp_en_i),
    .acc_i     (acc),
    .fsk_en_i  (fsk_en_i),
    .fsk_bit_i (fsk_bit_i),
    .fsk_inc_i (inc_w[2]),
    .irq_i     (irq_i),
    .off_o     (offset_o),
    .rb_o      (readback_o)
  );

endmodule

// File: tb/ramp_sweep_gen_tb.sv
`timescale 1ns/1ps
module ramp_sweep_gen_tb;

  logic        clk;
  logic        rst_n;
  logic        ramp_en;
  logic [1:0]  mode;
  logic        dual, set_sel;
  logic [19:0] steps_a, steps_b;
  logic [15:0] dev_a, dev_b, fsk_dev;
  logic [3:0]  dev_shift;
  logic [11:0] dwell_div;
  logic        start_en, gap_en, dly_unit;
  logic [11:0] dly_len;
  logic        fsk_en, fsk_bit, irq;
  logic [31:0] offset, readback;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int c_div, c_shift, c_na, c_nb, c_da, c_db, c_mode, c_dual, c_sel;
  int c_st, c_unit, c_len, c_gap;

  ramp_sweep_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ramp_en_i(ramp_en), .mode_i(mode),
    .dual_i(dual), .set_sel_i(set_sel), .steps_a_i(steps_a), .steps_b_i(steps_b),
    .dev_a_i(dev_a), .dev_b_i(dev_b), .dev_shift_i(dev_shift), .dwell_div_i(dwell_div),
    .start_dly_en_i(start_en), .gap_dly_en_i(gap_en), .dly_unit_i(dly_unit),
    .dly_len_i(dly_len), .fsk_en_i(fsk_en), .fsk_bit_i(fsk_bit), .fsk_dev_i(fsk_dev),
    .irq_i(irq), .offset_o(offset), .readback_o(readback)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_val(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int inc_of(input int i);
    if (c_dual != 0) return ((i < c_na) ? c_da : c_db) * (1 << c_shift);
    return ((c_sel != 0) ? c_db : c_da) * (1 << c_shift);
  endfunction

  function automatic int up_sum(input int k);
    int s = 0;
    for (int i = 0; i < k; i++) s += inc_of(i);
    return s;
  endfunction

  function automatic int nsteps();
    if (c_dual != 0) return c_na + c_nb;
    return (c_sel != 0) ? c_nb : c_na;
  endfunction

  // internal offset after edge m, counting the enabling edge as m = 0
  function automatic int exp_acc(input int m);
    int n, lu, start, r, k, p;
    if (m < 0) return 0;
    n     = nsteps();
    lu    = c_len * ((c_unit != 0) ? c_div : 1);
    start = (c_st != 0) ? lu : 0;
    if (m < start) return 0;
    r = m - start;
    case (c_mode)
      0: begin k = r / c_div; if (k > n) k = n; return up_sum(k); end
      1: begin k = r / c_div; return (k <= n) ? up_sum(k) : 0; end
      2: begin
        p = (n + 1) * c_div + ((c_gap != 0) ? lu : 0);
        k = (r % p) / c_div;
        return (k <= n) ? up_sum(k) : 0;
      end
      default: begin
        k = (r / c_div) % (2 * n);
        return (k <= n) ? up_sum(k) : up_sum(2 * n - k);
      end
    endcase
  endfunction

  task automatic apply_cfg();
    mode = c_mode[1:0]; dual = c_dual[0]; set_sel = c_sel[0];
    steps_a = c_na[19:0]; steps_b = c_nb[19:0];
    dev_a = c_da[15:0]; dev_b = c_db[15:0]; dev_shift = c_shift[3:0];
    dwell_div = c_div[11:0]; start_en = c_st[0]; gap_en = c_gap[0];
    dly_unit = c_unit[0]; dly_len = c_len[11:0];
  endtask

  task automatic run_case(input string tag, input int cycles, input int irq_at);
    int  v = 0;
    bit  pend = 0;
    @(negedge clk);
    apply_cfg();
    @(negedge clk);
    ramp_en = 1'b1;
    for (int m = 0; m < cycles; m++) begin
      @(negedge clk);
      check_val(tag, $signed(offset), exp_acc(m - 1));
      if (pend) begin
        irq  = 1'b0;
        pend = 0;
        check_val("R13 readback", $signed(readback), v);
      end
      if (m == irq_at) begin
        v    = $signed(offset);
        irq  = 1'b1;
        pend = 1;
      end
    end
    ramp_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_val("R12 disable", $signed(offset), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string mtag, ctag;
    rst_n = 1'b0; ramp_en = 1'b0; irq = 1'b0; fsk_en = 1'b0; fsk_bit = 1'b0;
    fsk_dev = 16'd0;
    c_div = 3; c_shift = 2; c_na = 3; c_nb = 2; c_da = 5; c_db = -3;
    c_mode = 0; c_dual = 0; c_sel = 0; c_st = 0; c_unit = 0; c_len = 1; c_gap = 0;
    apply_cfg();
    repeat (2) @(negedge clk);
    // R1: reset state
    check_val("R1 offset in reset", $signed(offset), 0);
    check_val("R1 readback in reset", $signed(readback), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_val("R1 offset after reset", $signed(offset), 0);
    check_val("R1 readback after reset", $signed(readback), 0);

    // R2: dwell of 4, exponent 3, negative deviation, burst
    c_div = 4; c_shift = 3; c_na = 3; c_da = -2; c_mode = 0;
    run_case("R2 dwell/scale", 24, -1);

    // shape/set/delay sweep
    for (int dv = 0; dv < 2; dv++) begin
      c_div = (dv == 0) ? 3 : 1; c_shift = (dv == 0) ? 2 : 0;
      c_na = 3; c_nb = 2; c_da = 5; c_db = -3;
      for (int md = 0; md < 4; md++)
        for (int du = 0; du < 2; du++)
          for (int sl = 0; sl < 2; sl++)
            for (int sc = 0; sc < 3; sc++)
              for (int gp = 0; gp < 2; gp++) begin
                if (gp == 1 && md != 2) continue;
                c_mode = md; c_dual = du; c_sel = sl; c_gap = gp;
                c_st = (sc != 0) ? 1 : 0;
                c_unit = (sc == 2) ? 1 : 0;
                c_len = (sc == 2) ? 2 : 4;
                case (md)
                  0: mtag = "R3";
                  1: mtag = "R4";
                  2: mtag = "R5";
                  default: mtag = "R6";
                endcase
                ctag = (du != 0) ? "R8" : "R7";
                if (sc != 0) ctag = {ctag, " R9"};
                if (gp != 0) ctag = {ctag, " R10"};
                run_case($sformatf("%s %s div%0d sel%0d", mtag, ctag, c_div, sl), 50, -1);
              end
    end

    // R13: capture during a looping sawtooth, sweep undisturbed
    c_div = 3; c_shift = 2; c_mode = 2; c_dual = 1; c_st = 0; c_gap = 0;
    run_case("R13 sweep during capture", 30, 10);

    // R11: shift overlay on a held burst
    c_div = 2; c_shift = 2; c_na = 3; c_da = 5; c_mode = 0; c_dual = 0; c_sel = 0;
    @(negedge clk);
    apply_cfg();
    fsk_dev = 16'd7; fsk_en = 1'b1; fsk_bit = 1'b0;
    @(negedge clk);
    ramp_en = 1'b1;
    repeat (12) @(negedge clk);
    check_val("R11 held peak", $signed(offset), 60);
    fsk_bit = 1'b1;
    @(negedge clk);
    check_val("R11 shift on", $signed(offset), 88);
    fsk_bit = 1'b0;
    @(negedge clk);
    check_val("R11 shift off", $signed(offset), 60);
    fsk_en = 1'b0; fsk_bit = 1'b1;
    @(negedge clk);
    check_val("R11 bit ignored when disabled", $signed(offset), 60);
    ramp_en = 1'b0;
    fsk_bit = 1'b0;
    repeat (2) @(negedge clk);
    check_val("R12 disable after overlay", $signed(offset), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule